// File: doc/BRIEF.md
# Switching Controller Fault Supervisor

This block decides whether the pulse-width modulator of a switching power controller may drive its power switch. Its inputs are flags that analog comparators have already digitized:

- the supply is above its turn-on level;
- the supply is below its turn-off level;
- the supply is over-voltage;
- the sampled output voltage is over-voltage;
- the current sense is above its shutdown level;
- the die is over-temperature;
- the die temperature has recovered.

A per-switching-cycle strobe arrives alongside these flags. From them the block produces three outputs: a run enable, a gate override that forces the gate low, and a 3-bit fault code.

Supply lockout uses hysteresis between two thresholds. Once the supply has risen past the turn-on level, it stays enabled until the turn-off flag appears. Most faults clear themselves when their condition goes away. The exception is an output over-voltage: it holds until the supply has passed through lockout and come back. The current-sense shutdown is confirmed over consecutive switching cycles before it acts. An over-temperature fault is latched, so while the die stays hot the controller cycles through lockout and restart without ever enabling the gate.

Each flag is registered once. Any input change therefore shows up on the outputs one clock later.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is low, and in the cycle after reset, the fault code is 1 (under-voltage), `run_en_o` is 0 and `gate_low_o` is 1.
- R2: The lockout is entered one clock after `sup_off_i` is seen high, and `sup_off_i` wins over `sup_on_i`. The lockout is left one clock after `sup_on_i` is seen high while `sup_off_i` is low. With both flags low, the lockout state holds.
- R3: Fault codes are: 0 none, 1 under-voltage, 2 over-temperature, 3 supply over-voltage, 4 output over-voltage, 5 sense shutdown. `run_en_o` is 1 and `gate_low_o` is 0 exactly when the code is 0.
- R4: The supply over-voltage fault follows `sup_ov_i` with one clock of delay and clears by itself.
- R5: The output over-voltage fault is latched when `out_ov_i` is seen high outside lockout. It clears only after lockout has been entered. A later `sup_on_i` then restarts the controller.
- R6: The over-temperature fault is set by `temp_hot_i`. It is cleared only by `temp_ok_i` while `temp_hot_i` is low.
- R7: While the over-temperature fault is held, leaving lockout does not enable the gate. The code returns to 2.
- R8: When several faults are active, the reported code is the one earliest in this order: under-voltage, over-temperature, supply over-voltage, output over-voltage, sense shutdown.
- R9: The sense shutdown (code 5) appears one clock after the third consecutive strobe that sees `sense_trip_i` high. Clocks without a strobe neither add to nor reset the count.
- R10: A strobe that sees `sense_trip_i` low resets the count. The sense shutdown releases one clock after `sense_trip_i` is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_on_i | input | 1 | Supply above turn-on level |
| sup_off_i | input | 1 | Supply below turn-off level |
| sup_ov_i | input | 1 | Supply over-voltage |
| out_ov_i | input | 1 | Sampled output over-voltage |
| sense_trip_i | input | 1 | Current sense above shutdown level |
| temp_hot_i | input | 1 | Over-temperature detected |
| temp_ok_i | input | 1 | Temperature recovered |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle |
| run_en_o | output | 1 | Controller may switch |
| gate_low_o | output | 1 | Force the gate driver low |
| fault_code_o | output | 3 | Highest-priority active fault |

## Verification
The assertions check several responses on every cycle:
- a turn-off flag forces the lockout code on the next clock;
- a supply over-voltage, an over-temperature flag or an output over-voltage during operation forces the gate low on the next clock;
- the gate only becomes enabled after a clock free of turn-off, supply over-voltage and hot flags;
- the sense shutdown only appears right after a strobe that saw the trip flag.

Some behaviour only the bench scenarios can show. These are the hysteresis hold between thresholds, the latching of the output over-voltage until a lockout pass, the hiccup while hot, the exact three-strobe count with its reset on a clean strobe, and the priority among overlapping faults.

// File: rtl/fss_pkg.sv
// Shared types for the fault supervisor.
// Assumes: code values are consumed by software-visible status elsewhere.
package fss_pkg;
    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_UV    = 3'd1,
        FC_OT    = 3'd2,
        FC_SUPOV = 3'd3,
        FC_OUTOV = 3'd4,
        FC_SENSE = 3'd5
    } fault_code_e;
endpackage

// File: rtl/fss_uvlo.sv
// Hysteretic supply lockout state.
// Assumes: on/off flags are already synchronised; off wins over on.
module fss_uvlo (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic off_i,
    output logic lock_o
);
    // Lockout register: set by off flag, cleared by on flag, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_o <= 1'b1;
        else if (off_i) lock_o <= 1'b1;
        else if (on_i)  lock_o <= 1'b0;
    end
endmodule

// File: rtl/fss_confirm.sv
// Consecutive-strobe confirmation of the sense shutdown flag.
// Assumes: strobe is a single-clock pulse per switching cycle.
module fss_confirm #(
    parameter int CONFIRM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic trip_i,
    output logic sd_o
);
    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);
    localparam logic [CW-1:0] TOP  = CW'(CONFIRM);

    logic [CW-1:0] cnt_q;

    // Count strobes seeing the trip flag; clean strobe or release clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (stb_i)
            cnt_q <= trip_i ? ((cnt_q == TOP) ? TOP : cnt_q + 1'b1) : '0;
        else if (sd_o && !trip_i)
            cnt_q <= '0;
    end

    // Shutdown latch: set on the confirming strobe, held while the flag stays.
    always_ff @(posedge clk) begin
        if (!rst_n)    sd_o <= 1'b0;
        else if (sd_o) sd_o <= trip_i;
        else           sd_o <= stb_i && trip_i && (cnt_q >= LAST);
    end
endmodule

// File: rtl/fss_prio.sv
// Fixed-priority encoder of active faults into the status code.
// Assumes: all inputs are registered fault states.
module fss_prio
    import fss_pkg::*;
(
    input  logic        uv_i,
    input  logic        ot_i,
    input  logic        supov_i,
    input  logic        outov_i,
    input  logic        sd_i,
    output fault_code_e code_o
);
    // Pick the highest-priority active fault.
    always_comb begin
        if (uv_i)         code_o = FC_UV;
        else if (ot_i)    code_o = FC_OT;
        else if (supov_i) code_o = FC_SUPOV;
        else if (outov_i) code_o = FC_OUTOV;
        else if (sd_i)    code_o = FC_SENSE;
        else              code_o = FC_NONE;
    end
endmodule

// File: rtl/fault_supervisor.sv
// Fault supervisor gating a switching controller's PWM output.
// Assumes: all flags are synchronous digitized comparator outputs.
module fault_supervisor
    import fss_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_on_i,
    input  logic       sup_off_i,
    input  logic       sup_ov_i,
    input  logic       out_ov_i,
    input  logic       sense_trip_i,
    input  logic       temp_hot_i,
    input  logic       temp_ok_i,
    input  logic       cyc_stb_i,
    output logic       run_en_o,
    output logic       gate_low_o,
    output logic [2:0] fault_code_o
);
    logic        uv_lock;
    logic        sd_act;
    logic        ot_q;
    logic        supov_q;
    logic        outov_q;
    fault_code_e code;

    fss_uvlo u_uvlo (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_i   (sup_on_i),
        .off_i  (sup_off_i),
        .lock_o (uv_lock)
    );

    fss_confirm #(.CONFIRM(CONFIRM)) u_confirm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (cyc_stb_i),
        .trip_i (sense_trip_i),
        .sd_o   (sd_act)
    );

    // Over-temperature latch: hot sets, recovered clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          ot_q <= 1'b0;
        else if (temp_hot_i) ot_q <= 1'b1;
        else if (temp_ok_i)  ot_q <= 1'b0;
    end

    // Supply over-voltage: registered copy, restarts automatically.
    always_ff @(posedge clk) begin
        if (!rst_n) supov_q <= 1'b0;
        else        supov_q <= sup_ov_i;
    end

    // Output over-voltage latch: cleared only while locked out.
    always_ff @(posedge clk) begin
        if (!rst_n)        outov_q <= 1'b0;
        else if (uv_lock)  outov_q <= 1'b0;
        else if (out_ov_i) outov_q <= 1'b1;
    end

    fss_prio u_prio (
        .uv_i    (uv_lock),
        .ot_i    (ot_q),
        .supov_i (supov_q),
        .outov_i (outov_q),
        .sd_i    (sd_act),
        .code_o  (code)
    );

    // Output mapping from the encoded status.
    always_comb begin
        fault_code_o = code;
        run_en_o     = (code == FC_NONE);
        gate_low_o   = (code != FC_NONE);
    end
endmodule

// File: rtl/fss_checker.sv
// Temporal checks on the fault supervisor ports.
// Assumes: bound to every instance of fault_supervisor.
module fss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_off_i,
    input logic       sup_ov_i,
    input logic       out_ov_i,
    input logic       sense_trip_i,
    input logic       temp_hot_i,
    input logic       cyc_stb_i,
    input logic       run_en_o,
    input logic       gate_low_o,
    input logic [2:0] fault_code_o
);
    assert_uv_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sup_off_i |=> (fault_code_o == 3'd1));

    assert_supov_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sup_ov_i |=> gate_low_o);

    assert_hot_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot_i |=> gate_low_o);

    assert_outov_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && out_ov_i) |=> gate_low_o);

    assert_start_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en_o) |-> $past(!sup_off_i && !sup_ov_i && !temp_hot_i));

    assert_sense_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_code_o == 3'd5) |-> $past(cyc_stb_i && sense_trip_i));
endmodule

bind fault_supervisor fss_checker u_fss_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_off_i    (sup_off_i),
    .sup_ov_i     (sup_ov_i),
    .out_ov_i     (out_ov_i),
    .sense_trip_i (sense_trip_i),
    .temp_hot_i   (temp_hot_i),
    .cyc_stb_i    (cyc_stb_i),
    .run_en_o     (run_en_o),
    .gate_low_o   (gate_low_o),
    .fault_code_o (fault_code_o)
);

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_on = 0, sup_off = 0, sup_ov = 0, out_ov = 0;
    logic sense = 0, hot = 0, tok = 0, stb = 0;
    logic run_en, gate_low;
    logic [2:0] code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit         chk;
        logic [2:0] code;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .sup_on_i(sup_on), .sup_off_i(sup_off),
        .sup_ov_i(sup_ov), .out_ov_i(out_ov), .sense_trip_i(sense),
        .temp_hot_i(hot), .temp_ok_i(tok), .cyc_stb_i(stb),
        .run_en_o(run_en), .gate_low_o(gate_low), .fault_code_o(code)
    );

    // Driver: push the expected outcome of the inputs just applied, advance.
    task automatic cyc(input bit chk, input logic [2:0] ec, input string tag);
        exp_t e;
        e.chk = chk; e.code = ec; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: one clock after each applied cycle, compare the outputs.
    initial forever begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.chk) begin
                n_chk++;
                if (code !== e.code || run_en !== (e.code == 3'd0) ||
                    gate_low !== (e.code != 3'd0)) begin
                    n_fail++;
                    $display("FAIL %s: code=%0d run=%0b low=%0b expected code=%0d",
                             e.tag, code, run_en, gate_low, e.code);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        sup_off = 1;
        // R1: reset state
        cyc(1, 3'd1, "R1 reset");
        cyc(1, 3'd1, "R1 reset");
        rst_n = 1;
        cyc(1, 3'd1, "R1 after reset");
        // R2: between thresholds lockout holds
        sup_off = 0;
        cyc(1, 3'd1, "R2 hold locked");
        // R2/R3: turn-on releases
        sup_on = 1;
        cyc(1, 3'd0, "R2 release");
        sup_on = 0;
        cyc(1, 3'd0, "R3 hold running");
        // R4: supply over-voltage auto-restart
        sup_ov = 1;
        cyc(1, 3'd3, "R4 supov");
        sup_ov = 0;
        cyc(1, 3'd0, "R4 restart");
        // R6: over-temperature latch
        hot = 1;
        cyc(1, 3'd2, "R6 hot");
        hot = 0;
        cyc(1, 3'd2, "R6 held");
        tok = 1;
        cyc(1, 3'd0, "R6 recovered");
        tok = 0;
        // R7/R8: hiccup while hot
        hot = 1;
        cyc(1, 3'd2, "R7 hot");
        hot = 0; sup_off = 1;
        cyc(1, 3'd1, "R8 uv over ot");
        sup_off = 0; sup_on = 1;
        cyc(1, 3'd2, "R7 restart blocked");
        sup_on = 0;
        cyc(1, 3'd2, "R7 still hot");
        tok = 1;
        cyc(1, 3'd0, "R7 cleared");
        tok = 0;
        // R5: output over-voltage latched until lockout pass
        out_ov = 1;
        cyc(1, 3'd4, "R5 outov");
        out_ov = 0;
        cyc(1, 3'd4, "R5 latched");
        sup_on = 1;
        cyc(1, 3'd4, "R5 on alone no clear");
        sup_on = 0; sup_off = 1;
        cyc(1, 3'd1, "R5 lockout");
        cyc(1, 3'd1, "R5 lockout");
        sup_off = 0; sup_on = 1;
        cyc(1, 3'd0, "R5 restart");
        sup_on = 0;
        // R8: supply OV outranks output OV
        out_ov = 1;
        cyc(1, 3'd4, "R8 outov");
        out_ov = 0; sup_ov = 1;
        cyc(1, 3'd3, "R8 supov first");
        sup_ov = 0;
        cyc(1, 3'd4, "R8 outov back");
        sup_off = 1;
        cyc(1, 3'd1, "R8 lockout");
        sup_off = 0; sup_on = 1;
        cyc(1, 3'd0, "R8 run");
        sup_on = 0;
        // R9/R10: sense confirmation
        sense = 1; stb = 1;
        cyc(1, 3'd0, "R9 strobe1");
        stb = 0;
        cyc(1, 3'd0, "R9 no strobe");
        stb = 1;
        cyc(1, 3'd0, "R9 strobe2");
        sense = 0;
        cyc(1, 3'd0, "R10 clean strobe");
        sense = 1;
        cyc(1, 3'd0, "R10 s1");
        cyc(1, 3'd0, "R10 s2");
        cyc(1, 3'd5, "R9 s3 trip");
        stb = 0;
        cyc(1, 3'd5, "R9 held");
        sense = 0;
        cyc(1, 3'd0, "R10 release");
        sense = 1; stb = 1;
        cyc(1, 3'd0, "R10 count restarted");
        stb = 0; sense = 0;
        cyc(1, 3'd0, "R10 idle");
        cyc(0, 3'd0, "drain");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule